// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block is the sending half of an asynchronous serial port. A host places a data word into a single-entry holding buffer with a one-cycle write strobe. When the shifter is free, the word moves into it and leaves on one output line in NRZ form. The line sits low for the start bit, then carries 5 to 9 data bits starting with the least significant, then an optional even or odd parity bit, then one or two high stop bits. Between frames the line idles high.

The bit rate comes from a built-in divider. A sub-bit tick fires once every `cfg_div + 1` clock cycles, and every bit on the line lasts 16 ticks. The host sees two flags. `buf_empty` says the holding buffer can take a word. `tx_done` says a frame has finished and nothing was waiting behind it. The holding buffer lets the host queue the next word while the current frame is still shifting out, so consecutive frames follow each other with no idle gap.

Top module: `serial_tx_core`

## Requirements
- R1: After reset `tx_line` is 1, `buf_empty` is 1 and `tx_done` is 0.
- R2: The sub-bit tick fires in the first cycle after reset and then every `cfg_div + 1` cycles, and `cfg_div` is read at each reload. Every bit of a frame holds the line for exactly 16 ticks, and the line changes only on the clock edge that closes a tick cycle.
- R3: A frame starts with one low start bit, followed by the data bits least significant first. `cfg_bits` selects the data width: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, and codes 4 to 7 give 9 bits. Data bits above the selected width have no effect on the line.
- R4: `cfg_par` selects the parity bit. Codes 00 and 01 send no parity bit. Code 10 sends even parity (the data bits plus the parity bit hold an even count of ones). Code 11 sends odd parity. The parity bit follows the last data bit.
- R5: One high stop bit is sent when `cfg_two_stop` is 0 and two when it is 1. Outside a frame the line is high.
- R6: A buffered word moves into an idle shifter on the next tick. If the shifter finishes a frame on a tick, the buffered word moves in on that same tick, so no idle bit appears between the frames. `buf_empty` rises on the edge where the word moves.
- R7: A write while `buf_empty` is 1 captures `wr_data`, and `buf_empty` reads 0 from the next cycle.
- R8: `tx_done` rises on the edge that ends a frame when no word is waiting in the buffer. It stays at 1 until a cycle in which `done_clr` is 1. If a frame ends in that same cycle, setting takes priority over clearing.
- R9: A write while `buf_empty` is 0 is ignored. The waiting word is sent unchanged, and the ignored data never appears on the line.
- R10: `cfg_bits`, `cfg_par` and `cfg_two_stop` are read on the edge where a word enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe for the holding buffer |
| wr_data | input | DATA_W (9) | Word to send |
| cfg_div | input | DIV_W (12) | Tick divisor; tick period is cfg_div + 1 cycles |
| cfg_bits | input | 3 | Data width code |
| cfg_par | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| done_clr | input | 1 | Clears tx_done |
| tx_line | output | 1 | Serial NRZ output, idle high |
| buf_empty | output | 1 | Holding buffer can accept a word |
| tx_done | output | 1 | Frame finished with an empty buffer |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor, up to 9 data bits and 16 ticks per bit. It keeps `cfg_div` between 0 and 3. That makes a whole 9-bit frame with parity and two stop bits short enough to run frame after frame in a few thousand cycles. A divisor of 0 makes every cycle a tick, which exposes the same-edge cases: the word moving into the shifter just as the previous frame ends, a full-buffer write arriving while the shifter is busy, and configuration changes landing mid-frame. The larger divisors check the tick spacing and the reload of the divisor value.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam logic [1:0] PAR_EVEN = 2'b10;
    localparam logic [1:0] PAR_ODD  = 2'b11;
    localparam int         MIN_BITS = 5;

    // width code to number of data bits, saturating at the widest supported frame
    function automatic int data_width(input logic [2:0] code, input int max_w);
        int w;
        w = MIN_BITS + int'(code);
        if (w > max_w) w = max_w;
        return w;
    endfunction

endpackage

// File: rtl/stx_tick_gen.sv
module stx_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == '0);
        if (tick) st_d.cnt = div;
        else      st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stx_hold_buf.sv
module stx_hold_buf #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] word
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] word;
    } hb_state_t;

    hb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        if (wr_en && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.word = wr_data;
        end
        full = st_q.full;
        word = st_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_word,
    input  logic [2:0]        cfg_bits,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_two_stop,
    input  logic              done_clr,
    output logic              take,
    output logic              busy,
    output logic              line,
    output logic              done
);
    import stx_pkg::*;

    localparam int FRAME_W = DATA_W + 4;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam int SUB_W   = (OVS > 1) ? $clog2(OVS) : 1;

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [SUB_W-1:0]   sub;
        logic [NB_W-1:0]    left;
        logic [FRAME_W-1:0] frame;
    } sh_state_t;

    sh_state_t st_d, st_q;

    int                 width;
    logic               par_en;
    logic               par_bit;
    logic               fin;
    logic [FRAME_W-1:0] img;
    logic [NB_W-1:0]    nbits;

    always_comb begin
        // frame image built from the waiting word and the current format
        width   = data_width(cfg_bits, DATA_W);
        par_en  = cfg_par[1];
        par_bit = 1'b0;
        for (int i = 0; i < DATA_W; i++)
            if (i < width) par_bit = par_bit ^ buf_word[i];
        if (cfg_par == PAR_ODD) par_bit = ~par_bit;

        img    = '1;
        img[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++)
            if (i < width) img[i+1] = buf_word[i];
        for (int i = 0; i <= DATA_W; i++)
            if (i == width && par_en) img[i+1] = par_bit;
        nbits = NB_W'(width + 2 + int'(par_en) + int'(cfg_two_stop));

        st_d = st_q;
        take = 1'b0;
        fin  = 1'b0;

        if (tick && st_q.busy) begin
            if (st_q.sub == SUB_W'(OVS - 1)) begin
                st_d.sub   = '0;
                st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                st_d.left  = st_q.left - 1'b1;
                if (st_q.left == NB_W'(1)) begin
                    st_d.busy = 1'b0;
                    fin       = 1'b1;
                end
            end else begin
                st_d.sub = st_q.sub + 1'b1;
            end
        end

        if (tick && !st_d.busy && buf_full) begin
            take       = 1'b1;
            st_d.busy  = 1'b1;
            st_d.sub   = '0;
            st_d.frame = img;
            st_d.left  = nbits;
        end

        if (done_clr)     st_d.done = 1'b0;
        if (fin && !take) st_d.done = 1'b1;

        busy = st_q.busy;
        line = st_q.busy ? st_q.frame[0] : 1'b1;
        done = st_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [2:0]        cfg_bits,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_two_stop,
    input  logic              done_clr,
    output logic              tx_line,
    output logic              buf_empty,
    output logic              tx_done
);

    logic              tick;
    logic              take;
    logic              buf_full;
    logic              sh_busy;
    logic [DATA_W-1:0] buf_word;

    stx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (cfg_div),
        .tick  (tick)
    );

    stx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (buf_full),
        .word    (buf_word)
    );

    stx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .buf_full     (buf_full),
        .buf_word     (buf_word),
        .cfg_bits     (cfg_bits),
        .cfg_par      (cfg_par),
        .cfg_two_stop (cfg_two_stop),
        .done_clr     (done_clr),
        .take         (take),
        .busy         (sh_busy),
        .line         (tx_line),
        .done         (tx_done)
    );

    assign buf_empty = ~buf_full;

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              take,
    input logic              buf_full,
    input logic [DATA_W-1:0] buf_word,
    input logic              sh_busy,
    input logic              wr_en,
    input logic              done_clr,
    input logic              tx_line,
    input logic              tx_done
);

    p_line_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tx_line));

    p_idle_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> tx_line);

    p_take_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (tick && buf_full));

    p_take_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!buf_full && sh_busy));

    p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !buf_full) |=> buf_full);

    p_done_rise_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (!sh_busy && !buf_full));

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !tick) |=> !tx_done);

    p_full_word_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !take) |=> (buf_full && $stable(buf_word)));

endmodule

bind serial_tx_core stx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .take     (take),
    .buf_full (buf_full),
    .buf_word (buf_word),
    .sh_busy  (sh_busy),
    .wr_en    (wr_en),
    .done_clr (done_clr),
    .tx_line  (tx_line),
    .tx_done  (tx_done)
);

// File: tb/tb_serial_tx_core.sv
`timescale 1ns/1ps
module tb_serial_tx_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic [11:0] cfg_div = '0;
    logic [2:0]  cfg_bits = 3'd3;
    logic [1:0]  cfg_par = 2'b00;
    logic        cfg_two_stop = 1'b0;
    logic        done_clr = 1'b0;
    logic        tx_line, buf_empty, tx_done;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    live = 1'b0;

    always #2 clk = ~clk;

    serial_tx_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_div(cfg_div), .cfg_bits(cfg_bits), .cfg_par(cfg_par),
        .cfg_two_stop(cfg_two_stop), .done_clr(done_clr),
        .tx_line(tx_line), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    // behavioural reference: the line content of a frame is held as a queue of bits
    int   m_cnt;
    int   m_sub;
    bit   m_full;
    bit   m_busy;
    bit   m_done;
    logic [8:0] m_word;
    bit   m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_sub = 0; m_full = 0; m_busy = 0; m_done = 0;
            m_word = '0; m_bits.delete();
        end else begin
            bit tk, was_full, ended, loaded;
            tk = (m_cnt == 0);
            m_cnt = tk ? int'(cfg_div) : m_cnt - 1;
            was_full = m_full;
            ended = 0; loaded = 0;
            if (tk && m_busy) begin
                m_sub++;
                if (m_sub == 16) begin
                    m_sub = 0;
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) begin m_busy = 0; ended = 1; end
                end
            end
            if (tk && !m_busy && was_full) begin
                int w, ones;
                w = (cfg_bits >= 3'd4) ? 9 : 5 + int'(cfg_bits);
                ones = 0;
                m_bits.push_back(1'b0);
                for (int i = 0; i < w; i++) begin
                    m_bits.push_back(m_word[i]);
                    ones += int'(m_word[i]);
                end
                if (cfg_par == 2'b10) m_bits.push_back(ones % 2 == 1);
                if (cfg_par == 2'b11) m_bits.push_back(ones % 2 == 0);
                m_bits.push_back(1'b1);
                if (cfg_two_stop) m_bits.push_back(1'b1);
                m_busy = 1; m_sub = 0; m_full = 0; loaded = 1;
            end
            if (done_clr) m_done = 0;
            if (ended && !loaded) m_done = 1;
            if (wr_en && !was_full) begin m_full = 1; m_word = wr_data; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && live) begin
            chk(cur_req, "tx_line", int'(tx_line), m_busy ? int'(m_bits[0]) : 1);
            chk(cur_req, "buf_empty", int'(buf_empty), int'(!m_full));
            chk(cur_req, "tx_done", int'(tx_done), int'(m_done));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [8:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (buf_empty && tx_done) break;
        end
        step();
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        step();
        done_clr = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset tx_line", int'(tx_line), 1);
        chk("R1", "reset buf_empty", int'(buf_empty), 1);
        chk("R1", "reset tx_done", int'(tx_done), 0);
        live = 1'b1;
        step();

        cur_req = "R3"; cfg_bits = 3'd3; send(9'h0A5); wait_quiet();
        cur_req = "R8";
        @(negedge clk); chk("R8", "done held", int'(tx_done), 1);
        step(); clear_done();
        @(negedge clk); chk("R8", "done cleared", int'(tx_done), 0);
        step();

        cur_req = "R3"; cfg_bits = 3'd0; send(9'h1F2); wait_quiet(); clear_done();
        cur_req = "R3"; cfg_bits = 3'd6; send(9'h10F); wait_quiet(); clear_done();

        cur_req = "R4"; cfg_bits = 3'd2; cfg_par = 2'b10; send(9'h013); wait_quiet(); clear_done();
        cur_req = "R4"; cfg_bits = 3'd4; cfg_par = 2'b11; send(9'h155); wait_quiet(); clear_done();
        cur_req = "R4"; cfg_bits = 3'd3; cfg_par = 2'b01; send(9'h0FF); wait_quiet(); clear_done();

        cur_req = "R5"; cfg_par = 2'b00; cfg_two_stop = 1'b1; send(9'h03C); wait_quiet(); clear_done();

        cur_req = "R2"; cfg_two_stop = 1'b0; cfg_div = 12'd2; send(9'h0C3); wait_quiet(); clear_done();
        cur_req = "R2"; cfg_div = 12'd3; cfg_bits = 3'd1; send(9'h02A); wait_quiet(); clear_done();

        cur_req = "R7"; cfg_div = 12'd1; cfg_bits = 3'd3;
        send(9'h081);
        @(negedge clk); chk("R7", "buf_empty after write", int'(buf_empty), 0);
        step(); wait_quiet(); clear_done();

        cur_req = "R6"; cfg_div = 12'd0;
        send(9'h0E1);
        send(9'h01E);
        for (int n = 0; n < 2000; n++) begin @(negedge clk); if (buf_empty) break; end
        step(); send(9'h077);
        wait_quiet(); clear_done();

        cur_req = "R9";
        send(9'h011);
        for (int n = 0; n < 200; n++) begin @(negedge clk); if (buf_empty) break; end
        step(); send(9'h022);
        send(9'h099);
        @(negedge clk); chk("R9", "buf_empty after ignored write", int'(buf_empty), 0);
        step(); wait_quiet(); clear_done();

        cur_req = "R10";
        send(9'h055);
        for (int n = 0; n < 200; n++) begin @(negedge clk); if (buf_empty) break; end
        step();
        cfg_bits = 3'd0; cfg_par = 2'b11; cfg_two_stop = 1'b1;
        wait_quiet(); clear_done();
        send(9'h1AA); wait_quiet(); clear_done();

        repeat (4) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule